// File: doc/BRIEF.md
# General-Purpose Timer with Edge Capture

This block is a 16-bit up-counter with a programmable power-of-two prescaler, a compare-match function and edge capture of one external input. Software drives it through a simple 32-bit register bus with a single write strobe. Reads are combinational from the address. The counter advances once per prescaled tick while its run bit is set. When the count equals the compare value, the counter either returns to zero (auto-reload) or freezes and drops its run bit (single-shot).

An external capture pin passes through a two-flop synchroniser. Its rising and falling edges can each copy the live count into a dedicated capture register. Three sticky status flags record match, falling capture and rising capture. Software clears a flag by writing 1 to it. One interrupt output is raised whenever any flag is set together with its enable bit.

Top module: `gp_timer`

## Requirements
- R1: After synchronous reset, count, control, status and both capture registers are zero, compare is 0xFFFF and `irq` is low.
- R2: Control bits [3:0] hold a prescaler code; code n in 0..8 advances the count once every 2^n clocks, and codes 9..15 behave as code 8 (every 256 clocks).
- R3: Control bit 5 is the run bit. While it is clear, the count holds its value, except that a bus write to the count register loads the written value.
- R4: With control bit 4 clear (auto-reload), a tick taken while count equals compare sets the count to 0 and sets status bit 0.
- R5: With control bit 4 set (single-shot), a tick taken while count equals compare leaves the count unchanged, clears control bit 5 and sets status bit 0.
- R6: With compare at 0xFFFF in auto-reload mode, the counter runs freely and wraps from 0xFFFF to 0.
- R7: Control bits [7:6] select which edges capture: bit 6 enables rising edges, bit 7 enables falling edges. A rising edge copies the count into the rising-capture register and sets status bit 2. A falling edge copies the count into the falling-capture register and sets status bit 1. An edge of a kind that is not enabled changes nothing. The capture is visible three clocks after the pin changes.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; an event in the same cycle as the clear wins.
- R9: `irq` is high exactly when some status bit is set and its enable is set: control bit 8 enables match, bit 9 enables falling capture and bit 10 enables rising capture.
- R10: Registers sit at byte addresses 0x80 control, 0x84 status, 0x88 compare, 0x8C count, 0x90 rising capture and 0x94 falling capture. The capture registers are read-only. Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the prescaler code is only rewritten while the run bit is clear. They also assume that `cap_in` holds each level for at least three clocks, so that the synchroniser passes every edge. The bench always stops the counter before it changes the prescaler code. It moves the capture pin only at falling clock edges and then waits three cycles. Count loads and status clears are issued only while no tick or edge event can coincide with them, except in the same-cycle case that R8 defines.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    // Control register layout, MSB first (bits 10..0)
    typedef struct packed {
        logic [2:0] irq_en;    // [2]=rising capture, [1]=falling capture, [0]=match
        logic [1:0] cap_sel;   // [1]=falling edges, [0]=rising edges
        logic       run;
        logic       one_shot;
        logic [3:0] psc_code;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        RG_CTRL   = 3'd0,
        RG_STAT   = 3'd1,
        RG_CMP    = 3'd2,
        RG_CNT    = 3'd3,
        RG_RCAP   = 3'd4,
        RG_FCAP   = 3'd5,
        RG_NONE   = 3'd7
    } reg_idx_t;

    localparam int NUM_REGS = 6;

    // Clamp a prescaler code to the largest supported exponent
    function automatic int eff_code(input logic [3:0] code, input int max_code);
        return (int'(code) > max_code) ? max_code : int'(code);
    endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PSC_MAX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] code,
    output logic       tick
);
    import gpt_pkg::*;

    localparam int PW = (PSC_MAX > 0) ? PSC_MAX : 1;

    logic [PW-1:0] div_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < PW; i++) begin
            if (i < eff_code(code, PSC_MAX)) limit[i] = 1'b1;
        end
    end

    assign tick = en && (div_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !en)  div_q <= '0;
        else if (tick)   div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    // R2: any code above zero spaces ticks at least two clocks apart
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && en && code != 4'd0) |=> !tick);

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         one_shot,
    input  logic [W-1:0] cmp,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         stop
);
    assign match = tick && (cnt == cmp);
    assign stop  = match && one_shot;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (ld)         cnt <= ld_val;
        else if (match)      cnt <= one_shot ? cnt : '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    // R3: no tick and no load keeps the count
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(cnt));
    // R4: auto-reload returns to zero after a match
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (match && !one_shot && !ld) |=> (cnt == '0));
    // R5: single-shot freezes on a match
    a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
        (match && one_shot && !ld) |=> $stable(cnt));

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic [1:0]   sel,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] rcap,
    output logic [W-1:0] fcap,
    output logic         rhit,
    output logic         fhit
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rhit = sel[0] &&  sync_q && !prev_q;
    assign fhit = sel[1] && !sync_q &&  prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcap <= '0;
            fcap <= '0;
        end else begin
            if (rhit) rcap <= cnt;
            if (fhit) fcap <= cnt;
        end
    end

    // R7: a selected edge stores the count present in that cycle
    a_r7_rise_store: assert property (@(posedge clk) disable iff (rst)
        rhit |=> (rcap == $past(cnt)));
    a_r7_fall_store: assert property (@(posedge clk) disable iff (rst)
        fhit |=> (fcap == $past(cnt)));

endmodule

// File: rtl/gp_timer.sv
module gp_timer #(
    parameter int          CNT_W   = 16,
    parameter int          PSC_MAX = 8,
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter logic [7:0]  BASE    = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    import gpt_pkg::*;

    localparam int SPAN = 4 * NUM_REGS;

    ctrl_t              ctrl_q;
    logic [2:0]         stat_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   rcap, fcap;
    logic               tick, match, stop, rhit, fhit;
    reg_idx_t           idx;
    logic [ADDR_W-1:0]  offs;

    // Address decode
    assign offs = bus_addr - ADDR_W'(BASE);
    always_comb begin
        idx = RG_NONE;
        if (bus_addr >= ADDR_W'(BASE) && int'(offs) < SPAN && offs[1:0] == 2'b00)
            idx = reg_idx_t'(offs[4:2]);
    end

    logic wr_ctrl, wr_stat, wr_cmp, wr_cnt;
    assign wr_ctrl = bus_wr && (idx == RG_CTRL);
    assign wr_stat = bus_wr && (idx == RG_STAT);
    assign wr_cmp  = bus_wr && (idx == RG_CMP);
    assign wr_cnt  = bus_wr && (idx == RG_CNT);

    gpt_prescaler #(.PSC_MAX(PSC_MAX)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.run),
        .code (ctrl_q.psc_code),
        .tick (tick)
    );

    gpt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .one_shot (ctrl_q.one_shot),
        .cmp      (cmp_q),
        .ld       (wr_cnt),
        .ld_val   (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .match    (match),
        .stop     (stop)
    );

    gpt_capture #(.W(CNT_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .pin  (cap_in),
        .sel  (ctrl_q.cap_sel),
        .cnt  (cnt),
        .rcap (rcap),
        .fcap (fcap),
        .rhit (rhit),
        .fhit (fhit)
    );

    // Control and compare
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '1;
        end else begin
            if (wr_ctrl)      ctrl_q     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            else if (stop)    ctrl_q.run <= 1'b0;
            if (wr_cmp)       cmp_q      <= bus_wdata[CNT_W-1:0];
        end
    end

    // Status: write-one-to-clear, new events win
    logic [2:0] clr, evt;
    assign clr = wr_stat ? bus_wdata[2:0] : 3'b000;
    assign evt = {rhit, fhit, match};

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | evt;
    end

    assign irq = |(stat_q & ctrl_q.irq_en);

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            RG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            RG_STAT: bus_rdata[2:0]        = stat_q;
            RG_CMP:  bus_rdata[CNT_W-1:0]  = cmp_q;
            RG_CNT:  bus_rdata[CNT_W-1:0]  = cnt;
            RG_RCAP: bus_rdata[CNT_W-1:0]  = rcap;
            RG_FCAP: bus_rdata[CNT_W-1:0]  = fcap;
            default: bus_rdata = '0;
        endcase
    end

    // R8: a clear with no coincident match leaves the match flag low
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[0] && !match) |=> !stat_q[0]);
    // R5: single-shot completion drops the run bit
    a_r5_run_off: assert property (@(posedge clk) disable iff (rst)
        (stop && !wr_ctrl) |=> !ctrl_q.run);
    // R9: no flags means no interrupt
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (stat_q == 3'b000) |-> !irq);

endmodule

// File: tb/gp_timer_tb.sv
module gp_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        cap_in;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gp_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    localparam logic [7:0] A_CTRL = 8'h80, A_STAT = 8'h84, A_CMP = 8'h88,
                           A_CNT  = 8'h8C, A_RCAP = 8'h90, A_FCAP = 8'h94;

    // {prescaler code, clocks to run, expected count}
    localparam logic [31:0] VEC [8] = '{
        {4'd0,  12'd10,  16'd10},
        {4'd1,  12'd10,  16'd5},
        {4'd2,  12'd11,  16'd2},
        {4'd3,  12'd20,  16'd2},
        {4'd4,  12'd33,  16'd2},
        {4'd8,  12'd300, 16'd1},
        {4'd12, 12'd256, 16'd1},
        {4'd15, 12'd255, 16'd0}
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CNT, v);  chk("R1 count", v, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_CMP, v);  chk("R1 compare", v, 32'hFFFF);
        rd(A_CTRL, v); chk("R1 control", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 prescaler table walk
        for (int i = 0; i < 8; i++) begin
            wr(A_CTRL, 32'h0);
            wr(A_CNT, 32'h0);
            wr(A_CTRL, 32'h20 | 32'(VEC[i][31:28]));
            idle(int'(VEC[i][27:16]));
            rd(A_CNT, v);
            chk("R2 prescaled count", v, 32'(VEC[i][15:0]));
        end
        wr(A_CTRL, 32'h0);

        // R3 counter held while run bit clear
        wr(A_CNT, 32'h5);
        idle(10);
        rd(A_CNT, v); chk("R3 hold", v, 32'h5);

        // R4 auto-reload at compare
        wr(A_STAT, 32'h7);
        wr(A_CMP, 32'h4);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h20);
        idle(5);
        rd(A_CNT, v);  chk("R4 reload to zero", v, 32'h0);
        rd(A_STAT, v); chk("R4 match flag", v, 32'h1);
        idle(2);
        rd(A_CNT, v);  chk("R4 counting again", v, 32'h2);

        // R5 single-shot
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h7);
        wr(A_CMP, 32'h3);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h30);
        idle(10);
        rd(A_CNT, v);  chk("R5 frozen at compare", v, 32'h3);
        rd(A_CTRL, v); chk("R5 run bit dropped", v, 32'h10);
        rd(A_STAT, v); chk("R5 match flag", v, 32'h1);

        // R6 free-running wrap
        wr(A_STAT, 32'h7);
        wr(A_CMP, 32'hFFFF);
        wr(A_CNT, 32'hFFFE);
        wr(A_CTRL, 32'h20);
        idle(2);
        rd(A_CNT, v);  chk("R6 wrap to zero", v, 32'h0);
        rd(A_STAT, v); chk("R6 match on wrap", v, 32'h1);
        wr(A_CTRL, 32'h0);

        // R8 writing zero keeps the flag, writing one clears it
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R8 zero write no effect", v, 32'h1);

        // R9 interrupt gating
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h100);
        chk("R9 irq on match enable", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h600);
        chk("R9 wrong enable no irq", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h100);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R8 one write clears", v, 32'h0);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R7 rising capture only
        wr(A_CTRL, 32'h440);
        wr(A_CNT, 32'h1234);
        cap_in = 1'b1;
        idle(2);
        rd(A_STAT, v); chk("R7 no capture before sync", v, 32'h0);
        idle(1);
        rd(A_RCAP, v); chk("R7 rising capture", v, 32'h1234);
        rd(A_STAT, v); chk("R7 rising flag", v, 32'h4);
        chk("R9 rising irq", {31'b0, irq}, 32'h1);
        cap_in = 1'b0;
        idle(3);
        rd(A_STAT, v); chk("R7 falling ignored", v, 32'h4);
        rd(A_FCAP, v); chk("R7 falling reg untouched", v, 32'h0);

        // R7 both edges
        wr(A_STAT, 32'h7);
        wr(A_CTRL, 32'hC0);
        wr(A_CNT, 32'h55AA);
        cap_in = 1'b1;
        idle(3);
        cap_in = 1'b0;
        idle(3);
        rd(A_RCAP, v); chk("R7 both rising", v, 32'h55AA);
        rd(A_FCAP, v); chk("R7 both falling", v, 32'h55AA);
        rd(A_STAT, v); chk("R7 both flags", v, 32'h6);

        // R10 map details
        wr(A_RCAP, 32'hBEEF);
        rd(A_RCAP, v); chk("R10 capture read-only", v, 32'h55AA);
        wr(A_CTRL, 32'h7D5);
        rd(A_CTRL, v); chk("R10 control readback", v, 32'h7D5);
        wr(A_CTRL, 32'h0);
        rd(8'h98, v);  chk("R10 unmapped reads zero", v, 32'h0);
        rd(8'h86, v);  chk("R10 misaligned reads zero", v, 32'h0);
        rd(8'h0C, v);  chk("R10 below base reads zero", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule